// File: doc/BRIEF.md
# Register Completer with Qualified Error Verdict

This block is a peripheral-side responder on an APB3 bus. It holds a small bank of read/write registers. A static input sets how many wait states each access takes. Every access ends with a completion cycle in which the block gives its pass/fail verdict. The verdict is registered together with the ready strobe, so it is valid exactly in the cycle the transfer completes.

Three conditions can fail an access, and they are ORed together:
- The address falls in the decoded window, but no register sits at that word.
- The protection attribute is unprivileged, but the target register accepts only privileged accesses.
- An external fault line from the peripheral core is high.

A failed transfer still completes. A failed write leaves every register unchanged, and a failed read returns all zeros.

Top module: `apb_err_regslave`

## Requirements
- R1: A synchronous active-low reset clears `ready`, `slv_err`, `rdata` and every register, so each register reads back as zero after reset.
- R2: With `wait_cycles` = N (0 to 3, sampled in the setup cycle), the access phase lasts exactly N+1 cycles. `ready` is low in the first N of them and high only in the last.
- R3: `slv_err` is high only in a cycle where `sel`, `enable` and `ready` are all high. It is 0 in wait cycles and in idle cycles.
- R4: The word index is `addr[7:2]`. An index of 8 or more selects no register and fails the access. Indexes 0 to 7 are the registers. `addr[1:0]` is ignored.
- R5: Registers 6 and 7 are privileged. An access to either of them with `prot[0]` = 0 fails. All other registers accept any `prot`.
- R6: If `fault` is high in the cycle before completion, the access fails. When `wait_cycles` = 0, that cycle is the setup cycle.
- R7: A write that completes without error stores all 32 bits of `wdata` in the addressed register. A write that completes with `slv_err` high changes no register.
- R8: A clean read returns the register value on `rdata` in the completion cycle. A failed read returns `rdata` = 0.
- R9: A failed access is never stalled. It completes after the same number of cycles as a clean access with the same wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 1 | Completer selected |
| enable | input | 1 | Access phase marker |
| write | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address within the window |
| wdata | input | 32 | Write data |
| prot | input | 3 | Protection attribute; bit 0 = privileged |
| fault | input | 1 | Peripheral fault for the current access |
| wait_cycles | input | 2 | Wait states to insert per access |
| rdata | output | 32 | Read data, valid in the completion cycle |
| ready | output | 1 | Transfer completes in this cycle |
| slv_err | output | 1 | Transfer failed; meaningful only with `ready` |

## Verification
In the completion cycle, the error verdict and the register write act at the same time. The write must be blocked in exactly the cycles where the verdict is high. The bench provokes this with three kinds of failing write: an unprivileged write to a privileged register, a write with `fault` raised, and a write to an unmapped word. Each is run under several wait counts. A clean read afterwards must show the previous value. A second overlap is the wait counter against the verdict. Failing accesses with three wait states must still complete on the counted cycle, and the error flag must stay low in every wait cycle before that.

// File: rtl/apbrs_pkg.sv
// Package: shared types for the register completer.
// Assumes: a fixed 32-bit data path; the error source record is used only for naming.
package apbrs_pkg;
    // The three independent reasons an access can fail
    typedef struct packed {
        logic unmapped;
        logic prot_fail;
        logic fault;
    } err_src_t;

    // Collapse the sources into one verdict
    function automatic logic any_err(input err_src_t s);
        return s.unmapped | s.prot_fail | s.fault;
    endfunction
endpackage

// File: rtl/apbrs_judge.sv
// Module: apbrs_judge
// Decodes the word index and forms the error verdict for the current access.
// Assumes: byte address, word-aligned registers, and a NUM_REGS that fits the index width.
module apbrs_judge
    import apbrs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_REGS  = 8,
    parameter logic [NUM_REGS-1:0] PRIV_MASK = 8'hC0,
    localparam int unsigned WORD_W   = ADDR_W - 2,
    localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              privileged,
    input  logic              fault,
    output logic [IDX_W-1:0]  idx,
    output err_src_t          src,
    output logic              err
);
    localparam logic [WORD_W-1:0] LIMIT = WORD_W'(NUM_REGS);

    logic [WORD_W-1:0] word;
    logic              mapped;

    // Decode the word and judge each error source
    always_comb begin
        word          = addr[ADDR_W-1:2];
        mapped        = (word < LIMIT);
        idx           = word[IDX_W-1:0];
        src.unmapped  = !mapped;
        src.prot_fail = mapped && PRIV_MASK[idx] && !privileged;
        src.fault     = fault;
        err           = any_err(src);
    end
endmodule

// File: rtl/apbrs_resp.sv
// Module: apbrs_resp
// Counts wait states and registers ready, the verdict and the read data in one process.
// Assumes: the requester holds its address and controls stable until ready.
module apbrs_resp #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              enable,
    input  logic              write,
    input  logic [WAIT_W-1:0] wait_cycles,
    input  logic              err,
    input  logic [DATA_W-1:0] rd_word,
    output logic              ready,
    output logic              slv_err,
    output logic [DATA_W-1:0] rdata
);
    logic [WAIT_W-1:0] cnt;
    logic [WAIT_W-1:0] tgt;
    logic              setup_c;
    logic              access_c;
    logic              finish;

    // Decide whether the next edge ends the transfer
    always_comb begin
        setup_c  = sel && !enable;
        access_c = sel && enable;
        finish   = (setup_c && (wait_cycles == '0)) ||
                   (access_c && !ready && (cnt == tgt));
    end

    // Register ready, the verdict and the read data together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready   <= 1'b0;
            slv_err <= 1'b0;
            rdata   <= '0;
            cnt     <= '0;
            tgt     <= '0;
        end else begin
            ready   <= 1'b0;
            slv_err <= 1'b0;
            rdata   <= '0;
            if (finish) begin
                ready   <= 1'b1;
                slv_err <= err;
                rdata   <= (err || write) ? '0 : rd_word;
            end else if (setup_c) begin
                tgt <= wait_cycles;
                cnt <= WAIT_W'(1);
            end else if (access_c && !ready) begin
                cnt <= cnt + WAIT_W'(1);
            end
        end
    end

    // R2
    zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !enable && wait_cycles == '0) |=> ready);
    // R2
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    // R3
    err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slv_err |-> (sel && enable && ready));
endmodule

// File: rtl/apbrs_bank.sv
// Module: apbrs_bank
// Register storage with one write port and a combinational read mux.
// Assumes: the write enable is already qualified by completion and a clean verdict.
module apbrs_bank #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             idx,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rd_word,
    output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Hold one register; load it on a clean write to its index
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && (idx == IDX_W'(g)))
                regs[g] <= wdata;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    // Select the addressed register for reading
    always_comb rd_word = regs[idx];

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));
endmodule

// File: rtl/apb_err_regslave.sv
// Module: apb_err_regslave
// APB3 register completer with programmable wait states and a three-source error verdict.
// Assumes: a single requester and stable controls through each access.
module apb_err_regslave #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned WAIT_W   = 2,
    parameter logic [NUM_REGS-1:0] PRIV_MASK = 8'hC0,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              enable,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [2:0]        prot,
    input  logic              fault,
    input  logic [WAIT_W-1:0] wait_cycles,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              slv_err
);
    import apbrs_pkg::*;

    logic [IDX_W-1:0]           idx;
    err_src_t                   src;
    logic                       err;
    logic [DATA_W-1:0]          rd_word;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;
    logic                       wr_en;

    apbrs_judge #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .PRIV_MASK(PRIV_MASK)) u_judge (
        .addr(addr), .privileged(prot[0]), .fault(fault),
        .idx(idx), .src(src), .err(err)
    );

    apbrs_resp #(.DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .sel(sel), .enable(enable), .write(write),
        .wait_cycles(wait_cycles), .err(err), .rd_word(rd_word),
        .ready(ready), .slv_err(slv_err), .rdata(rdata)
    );

    // Commit a write only on a clean completion
    always_comb wr_en = sel && enable && ready && write && !slv_err;

    apbrs_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .wdata(wdata),
        .rd_word(rd_word), .regs_flat(regs_flat)
    );

    // R7
    err_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && enable && ready && write && slv_err) |=> $stable(regs_flat));
    // R8
    rd_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && slv_err && !write) |-> (rdata == '0));
    // R3
    wait_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && enable && !ready) |-> !slv_err);
endmodule

// File: tb/sim_apb_err_regslave.sv
module sim_apb_err_regslave;
    typedef struct {
        bit          is_read;
        bit          err;
        logic [31:0] data;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, enable = 1'b0, write = 1'b0, fault = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [2:0]  prot = '0;
    logic [1:0]  wait_cycles = '0;
    logic [31:0] rdata;
    logic        ready, slv_err;

    int checks = 0;
    int fails  = 0;
    exp_t exp_q[$];
    logic [31:0] model [8];

    always #2 clk = ~clk;

    apb_err_regslave u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .enable(enable), .write(write),
        .addr(addr), .wdata(wdata), .prot(prot), .fault(fault),
        .wait_cycles(wait_cycles), .rdata(rdata), .ready(ready), .slv_err(slv_err)
    );

    // Monitor: compare completions against the scoreboard, and check wait cycles stay clean
    always @(negedge clk) begin
        if (rst_n && sel && enable && ready) begin
            exp_t e;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R9: unexpected completion, got 1 expected 0");
            end else begin
                e = exp_q.pop_front();
                checks++;
                if (slv_err !== e.err) begin
                    fails++;
                    $display("FAIL %s: slv_err got %0b expected %0b", e.req, slv_err, e.err);
                end
                if (e.is_read) begin
                    checks++;
                    if (rdata !== e.data) begin
                        fails++;
                        $display("FAIL %s/R8: rdata got %h expected %h", e.req, rdata, e.data);
                    end
                end
            end
        end else if (rst_n && sel && enable && !ready) begin
            checks++;
            if (slv_err !== 1'b0) begin
                fails++;
                $display("FAIL R3: slv_err in wait cycle got %0b expected 0", slv_err);
            end
        end
    end

    // Driver: predict the outcome, push it, then run one transfer
    task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input bit p0, input logic [1:0] w, input bit f, input string rq);
        exp_t e;
        int   idx = int'(a[7:2]);
        bit   er;
        int   cyc = 0;
        er = (idx >= 8) || ((idx == 6 || idx == 7) && !p0) || f;
        e.is_read = !wr;
        e.err     = er;
        e.data    = (er || idx >= 8) ? 32'h0 : model[idx];
        e.req     = rq;
        exp_q.push_back(e);
        if (wr && !er) model[idx] = d;
        @(negedge clk);
        sel = 1'b1; enable = 1'b0; write = wr; addr = a; wdata = d;
        prot = {2'b00, p0}; wait_cycles = w; fault = f;
        @(negedge clk);
        enable = 1'b1;
        forever begin
            cyc++;
            if (ready === 1'b1 || cyc > 20) break;
            @(negedge clk);
        end
        checks++;
        if (cyc != int'(w) + 1) begin
            fails++;
            $display("FAIL R2/R9 (%s): access cycles got %0d expected %0d", rq, cyc, int'(w) + 1);
        end
        @(negedge clk);
        sel = 1'b0; enable = 1'b0; fault = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (ready !== 1'b0 || slv_err !== 1'b0 || rdata !== 32'h0) begin
            fails++;
            $display("FAIL R1: ready/slv_err/rdata got %b/%b/%h expected 0/0/0", ready, slv_err, rdata);
        end
        for (int i = 0; i < 8; i++) model[i] = 32'h0;
        rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, got timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1: all registers read zero after reset
        for (int i = 0; i < 8; i++) xfer(0, 8'(i * 4), 0, 1, 2'(i % 4), 0, "R1");
        // R7/R2: clean writes across wait counts, then readback
        for (int i = 0; i < 6; i++) xfer(1, 8'(i * 4 + (i % 4)), 32'hA5000000 + i * 32'h1111, 0, 2'(i % 4), 0, "R7");
        for (int i = 0; i < 6; i++) xfer(0, 8'(i * 4), 0, 0, 2'(3 - i % 4), 0, "R7");
        // R5: unprivileged write to privileged register blocked
        xfer(1, 8'h18, 32'hDEADBEEF, 0, 2'd3, 0, "R5");
        xfer(0, 8'h18, 0, 1, 2'd0, 0, "R5");
        xfer(1, 8'h1C, 32'h12345678, 1, 2'd1, 0, "R5");
        xfer(0, 8'h1C, 0, 0, 2'd2, 0, "R5");
        xfer(0, 8'h1C, 0, 1, 2'd0, 0, "R5");
        // R4: unmapped words fail under every wait count
        for (int w = 0; w < 4; w++) begin
            xfer(1, 8'h20 + 8'(w * 4), 32'hFFFFFFFF, 1, 2'(w), 0, "R4");
            xfer(0, 8'hFC, 0, 1, 2'(w), 0, "R4");
        end
        xfer(0, 8'h00, 0, 1, 2'd0, 0, "R4");
        // R6: fault blocks a write and fails a read
        xfer(1, 8'h08, 32'h0BADF00D, 1, 2'd3, 1, "R6");
        xfer(1, 8'h0C, 32'h0BADF00D, 1, 2'd0, 1, "R6");
        xfer(0, 8'h08, 0, 1, 2'd1, 0, "R6");
        xfer(0, 8'h0C, 0, 1, 2'd1, 1, "R6");
        xfer(0, 8'h0C, 0, 1, 2'd2, 0, "R6");
        // R1: reset after writes clears the bank
        do_reset();
        for (int i = 0; i < 8; i++) xfer(0, 8'(i * 4), 0, 1, 2'd0, 0, "R1");
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule